// File: doc/BRIEF.md
# Crossing-Indexed Triggered Hit Buffer

This block sits behind a hit combiner. Each hit word carries a 6-bit beam-crossing timestamp. The block files the hit into one of 64 storage buckets, using that timestamp as the bucket number, so storage follows crossing time and not the order in which hits arrive.

A local crossing counter steps once for each beam-clock strobe and wraps after 64 crossings. Each time the counter steps onto a bucket, that bucket is emptied, so a bucket holds data for less than one full turn of the counter.

A level-1 accept arrives a fixed number of crossings after its collision. That number is the `LATENCY` parameter, 42 by default. The accept picks the bucket for that collision and queues its index. When the output engine is free, it copies the bucket into an output buffer in a single cycle. It then sends the event downstream as 20-bit words: one header, one word per hit, and one trailer. An event whose crossing holds no hits is still sent, with no hit words.

Top module: `trig_bucket_buf`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid`, `busy` and `drop_count` are all zero.
- R2: The crossing counter starts at 0 and advances by one, modulo 64, in each cycle where `bco_strobe` is high. An accepted hit is stored in the bucket whose number equals its `hit_ts`.
- R3: An accept sampled while the counter holds C selects bucket (C - LATENCY) mod 64. With the default LATENCY of 42 this selection wraps below zero, so C = 0 selects bucket 22.
- R4: Every event starts with a header word. Bits [19:18] are 01, bits [17:6] are the event counter and bits [5:0] are the selected bucket number.
- R5: After the header comes one word per stored hit, in the order the hits were accepted. Bits [19:16] of each hit word are 0000 and bits [15:0] are the hit data.
- R6: A bucket holds at most 16 hits. A hit that arrives for a full bucket is not stored and sets that bucket's overflow flag. The trailer word ends the event: bits [19:18] are 11, bit 17 is the overflow flag, bits [16:5] are zero and bits [4:0] are the number of stored hits.
- R7: An accept for a bucket that holds no hits still produces exactly one header word followed directly by a trailer word with count 0 and overflow flag 0.
- R8: In a strobe cycle, bucket (C + 1) mod 64 is emptied and its overflow flag is cleared. A hit for that bucket in the same cycle is dropped and increments `drop_count`. Hits stored in a bucket before the counter last stepped onto it never appear in an event.
- R9: The bucket copy happens in the first cycle in which an accept is pending and the output engine is idle. After an accept that finds the engine idle and the queue empty, this is the next cycle. A hit for the bucket being copied in that cycle is dropped, is missing from the event, and increments `drop_count`.
- R10: Up to 4 accepts can be pending. The queued count is taken as it stands before the cycle's edge, with no credit for a copy in the same cycle. `busy` is high while 4 are pending. An accept that arrives while `busy` is high is discarded and produces no event.
- R11: The event counter starts at 0 after reset. It increments by one, wrapping at 12 bits, after each event is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bco_strobe | input | 1 | One-cycle pulse for each beam crossing |
| hit_valid | input | 1 | A hit word is present this cycle |
| hit_ts | input | 6 | Crossing timestamp of the hit |
| hit_data | input | 16 | Hit payload |
| l1_accept | input | 1 | Level-1 accept pulse |
| out_valid | output | 1 | `out_word` holds an event word |
| out_word | output | 20 | Header, hit or trailer word |
| busy | output | 1 | Accept queue is full |
| drop_count | output | 8 | Wrapping count of hits dropped by clear or copy collisions |

## Verification
Random traffic is driven with strobes about every eighth cycle and hits stamped zero to two crossings in the past. It checks bucket filing, the modulo-64 bucket selection across several counter wraps, hit ordering and the event counter against a bench model of the buckets.

Directed cases then separate behaviours that random traffic cannot tell apart:
- an empty event right after reset;
- a bucket filled past 16 hits;
- a hit aimed at the bucket being cleared;
- a bucket revisited after a full counter turn, which must read empty;
- a hit aimed at the bucket in its copy cycle;
- a burst of six accepts behind a long event, where only the sixth is rejected.

// File: rtl/tbb_pkg.sv
package tbb_pkg;
   typedef enum logic [1:0] {
      WK_HIT = 2'b00,
      WK_HDR = 2'b01,
      WK_TRL = 2'b11
   } wkind_t;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_HDR,
      FS_HIT,
      FS_TRL
   } fstate_t;
endpackage

// File: rtl/tbb_bucket_store.sv
module tbb_bucket_store #(
   parameter int TS_W   = 6,
   parameter int CAP    = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = $clog2(CAP + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [TS_W-1:0]               wr_ts,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          clr_en,
   input  logic [TS_W-1:0]               clr_idx,
   input  logic [TS_W-1:0]               rd_idx,
   output logic [CNT_W-1:0]              rd_count,
   output logic                          rd_ovf,
   output logic [CAP-1:0][DATA_W-1:0]    rd_data
);
   localparam int NB     = 1 << TS_W;
   localparam int SLOT_W = (CAP > 1) ? $clog2(CAP) : 1;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(CAP);

   logic [CNT_W-1:0]  fill [NB];
   logic [NB-1:0]     ovf;
   logic [DATA_W-1:0] mem  [NB][CAP];

   if (CNT_W < $clog2(CAP + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for CAP");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) fill[b] <= '0;
         ovf <= '0;
      end else begin
         for (int b = 0; b < NB; b++) begin
            if (clr_en && clr_idx == TS_W'(b)) begin
               fill[b] <= '0;
               ovf[b]  <= 1'b0;
            end else if (wr_en && wr_ts == TS_W'(b)) begin
               if (fill[b] == FULL) ovf[b] <= 1'b1;
               else                 fill[b] <= fill[b] + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && fill[wr_ts] != FULL)
         mem[wr_ts][SLOT_W'(fill[wr_ts])] <= wr_data;
   end

   always_comb begin
      rd_count = fill[rd_idx];
      rd_ovf   = ovf[rd_idx];
      for (int s = 0; s < CAP; s++) rd_data[s] = mem[rd_idx][s];
   end

   // R6: a write into a full bucket leaves it full and flags overflow
   a_r6_full_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fill[wr_ts] == FULL && !(clr_en && clr_idx == wr_ts))
      |=> (fill[$past(wr_ts)] == FULL && ovf[$past(wr_ts)]));

   // R8: a cleared bucket is empty with no overflow on the next cycle
   a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> (fill[$past(clr_idx)] == '0 && !ovf[$past(clr_idx)]));
endmodule

// File: rtl/tbb_accept_queue.sv
module tbb_accept_queue #(
   parameter int DEPTH = 4,
   parameter int W     = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         valid,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   assign full    = (cnt == DEPTH_C);
   assign valid   = (cnt != '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && valid;
   assign dout    = slot[rp];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_mod
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nx;
         if (pop_ok)  rp <= rp_nx;
         if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
         else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) slot[wp] <= din;
   end

   // R10: the pending count never exceeds the queue depth
   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DEPTH_C);

   // R10: an accept while full is discarded, the write pointer holds
   a_r10_reject_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wp)));
endmodule

// File: rtl/tbb_framer.sv
module tbb_framer import tbb_pkg::*; #(
   parameter int TS_W   = 6,
   parameter int CAP    = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = $clog2(CAP + 1),
   parameter int OUT_W  = 20
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        q_valid,
   input  logic [TS_W-1:0]             q_idx,
   output logic                        q_pop,
   input  logic [CNT_W-1:0]            b_count,
   input  logic                        b_ovf,
   input  logic [CAP-1:0][DATA_W-1:0]  b_data,
   output logic                        out_valid,
   output logic [OUT_W-1:0]            out_word
);
   localparam int EVC_W  = OUT_W - 2 - TS_W;
   localparam int SLOT_W = (CAP > 1) ? $clog2(CAP) : 1;

   if (OUT_W < DATA_W + 2 || OUT_W < CNT_W + 3 || EVC_W < 1) begin : g_bad_w
      $error("OUT_W too narrow for the word fields");
   end

   fstate_t                     st;
   logic [TS_W-1:0]             idx_r;
   logic [CNT_W-1:0]            cnt_r, ptr;
   logic                        ovf_r;
   logic [CAP-1:0][DATA_W-1:0]  buf_r;
   logic [EVC_W-1:0]            evc;

   assign q_pop     = (st == FS_IDLE) && q_valid;
   assign out_valid = (st != FS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= FS_IDLE;
         ptr <= '0;
         evc <= '0;
      end else begin
         unique case (st)
            FS_IDLE: if (q_pop) st <= FS_HDR;
            FS_HDR: begin
               ptr <= '0;
               st  <= (cnt_r == '0) ? FS_TRL : FS_HIT;
            end
            FS_HIT: begin
               ptr <= ptr + 1'b1;
               if (ptr == cnt_r - 1'b1) st <= FS_TRL;
            end
            FS_TRL: begin
               evc <= evc + 1'b1;
               st  <= FS_IDLE;
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (q_pop) begin
         idx_r <= q_idx;
         cnt_r <= b_count;
         ovf_r <= b_ovf;
         buf_r <= b_data;
      end
   end

   always_comb begin
      out_word = '0;
      unique case (st)
         FS_HDR: begin
            out_word[OUT_W-1 -: 2]  = WK_HDR;
            out_word[TS_W +: EVC_W] = evc;
            out_word[TS_W-1:0]      = idx_r;
         end
         FS_HIT: begin
            out_word[OUT_W-1 -: 2] = WK_HIT;
            out_word[DATA_W-1:0]   = buf_r[SLOT_W'(ptr)];
         end
         FS_TRL: begin
            out_word[OUT_W-1 -: 2] = WK_TRL;
            out_word[OUT_W-3]      = ovf_r;
            out_word[CNT_W-1:0]    = cnt_r;
         end
         default: out_word = '0;
      endcase
   end

   // R4: every event opens with a header word
   a_r4_header_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_word[OUT_W-1 -: 2] == WK_HDR));

   // R6: every event closes with a trailer word
   a_r6_trailer_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> ($past(out_word[OUT_W-1 -: 2]) == WK_TRL));

   // R5: hit words never read beyond the copied count
   a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_HIT) |-> (ptr < cnt_r));
endmodule

// File: rtl/trig_bucket_buf.sv
module trig_bucket_buf import tbb_pkg::*; #(
   parameter int TS_W    = 6,
   parameter int CAP     = 16,
   parameter int DATA_W  = 16,
   parameter int OUT_W   = 20,
   parameter int LATENCY = 42,
   parameter int QDEPTH  = 4,
   parameter int DROP_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bco_strobe,
   input  logic              hit_valid,
   input  logic [TS_W-1:0]   hit_ts,
   input  logic [DATA_W-1:0] hit_data,
   input  logic              l1_accept,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_word,
   output logic              busy,
   output logic [DROP_W-1:0] drop_count
);
   localparam int NB    = 1 << TS_W;
   localparam int CNT_W = $clog2(CAP + 1);
   localparam logic [TS_W-1:0] ONE = TS_W'(1);

   if (LATENCY < 1 || LATENCY >= NB) begin : g_bad_lat
      $error("LATENCY must lie in 1..NB-1");
   end

   logic [TS_W-1:0]             xcnt, clr_idx, acc_idx, pop_idx;
   logic                        q_valid, q_pop, q_full;
   logic                        drop_clr, drop_rd, hit_wr;
   logic [CNT_W-1:0]            b_count;
   logic                        b_ovf;
   logic [CAP-1:0][DATA_W-1:0]  b_data;

   assign clr_idx  = xcnt + ONE;
   assign acc_idx  = xcnt - TS_W'(LATENCY);
   assign drop_clr = hit_valid && bco_strobe && (hit_ts == clr_idx);
   assign drop_rd  = hit_valid && q_pop && (hit_ts == pop_idx);
   assign hit_wr   = hit_valid && !drop_clr && !drop_rd;
   assign busy     = q_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xcnt       <= '0;
         drop_count <= '0;
      end else begin
         if (bco_strobe)          xcnt       <= clr_idx;
         if (drop_clr || drop_rd) drop_count <= drop_count + 1'b1;
      end
   end

   tbb_bucket_store #(.TS_W(TS_W), .CAP(CAP), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit_wr),
      .wr_ts    (hit_ts),
      .wr_data  (hit_data),
      .clr_en   (bco_strobe),
      .clr_idx  (clr_idx),
      .rd_idx   (pop_idx),
      .rd_count (b_count),
      .rd_ovf   (b_ovf),
      .rd_data  (b_data)
   );

   tbb_accept_queue #(.DEPTH(QDEPTH), .W(TS_W)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (l1_accept),
      .din   (acc_idx),
      .pop   (q_pop),
      .dout  (pop_idx),
      .valid (q_valid),
      .full  (q_full)
   );

   tbb_framer #(.TS_W(TS_W), .CAP(CAP), .DATA_W(DATA_W), .CNT_W(CNT_W), .OUT_W(OUT_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_valid   (q_valid),
      .q_idx     (pop_idx),
      .q_pop     (q_pop),
      .b_count   (b_count),
      .b_ovf     (b_ovf),
      .b_data    (b_data),
      .out_valid (out_valid),
      .out_word  (out_word)
   );

   // R2: the crossing counter steps by one, wrapping, on each strobe
   a_r2_xing_step: assert property (@(posedge clk) disable iff (!rst_n)
      bco_strobe |=> (xcnt == $past(xcnt) + ONE));

   // R2: the crossing counter holds without a strobe
   a_r2_xing_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bco_strobe |=> $stable(xcnt));

   // R8 and R9: every collision drop advances the drop counter
   a_r8_r9_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_clr || drop_rd) |=> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: tb/trig_bucket_buf_test.sv
module trig_bucket_buf_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bco_strobe = 1'b0;
   logic        hit_valid = 1'b0;
   logic [5:0]  hit_ts = '0;
   logic [15:0] hit_data = '0;
   logic        l1_accept = 1'b0;
   logic        out_valid, busy;
   logic [19:0] out_word;
   logic [7:0]  drop_count;

   trig_bucket_buf uut (
      .clk(clk), .rst_n(rst_n), .bco_strobe(bco_strobe), .hit_valid(hit_valid),
      .hit_ts(hit_ts), .hit_data(hit_data), .l1_accept(l1_accept),
      .out_valid(out_valid), .out_word(out_word), .busy(busy), .drop_count(drop_count)
   );

   always #2 clk = ~clk;

   int          n_chk = 0, n_bad = 0;
   string       cur_req = "R1";
   int          bfill [64];
   bit          bovf  [64];
   logic [15:0] bmem  [64][16];
   int          xc = 0, evc = 0, drops = 0;
   logic [19:0] exp_q [$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s: actual %0h expected no word", cur_req, out_word);
         end else begin
            chk(cur_req, 32'(out_word), 32'(exp_q.pop_front()));
         end
      end
   end

   // mode 0: normal, 1: accept is expected to be rejected, 2: hit hits the copy cycle
   task automatic step(bit s, bit hv, logic [5:0] ts, logic [15:0] d, bit acc, int mode);
      logic [5:0] idx, nxt;
      @(negedge clk);
      bco_strobe = s; hit_valid = hv; hit_ts = ts; hit_data = d; l1_accept = acc;
      nxt = 6'(xc) + 6'd1;
      if (hv) begin
         if ((s && ts == nxt) || mode == 2) drops++;
         else if (bfill[ts] < 16) begin bmem[ts][bfill[ts]] = d; bfill[ts]++; end
         else bovf[ts] = 1'b1;
      end
      if (acc && mode != 1) begin
         idx = 6'(xc) - 6'd42;
         exp_q.push_back({2'b01, 12'(evc), idx});
         for (int i = 0; i < bfill[idx]; i++) exp_q.push_back({4'b0000, bmem[idx][i]});
         exp_q.push_back({2'b11, bovf[idx], 12'd0, 5'(bfill[idx])});
         evc++;
      end
      if (s) begin bfill[nxt] = 0; bovf[nxt] = 1'b0; xc = (xc + 1) % 64; end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 6'd0, 16'd0, 0, 0);
   endtask

   task automatic strobes(int n);
      for (int i = 0; i < n; i++) step(1, 0, 6'd0, 16'd0, 0, 0);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5813));
      repeat (4) @(negedge clk);
      chk("R1 out_valid in reset", 32'(out_valid), 0);
      chk("R1 busy in reset", 32'(busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid", 32'(out_valid), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 drop_count", 32'(drop_count), 0);

      // R7 and R3: empty event with wrap below zero (counter 0 selects bucket 22)
      cur_req = "R7 R3 empty event";
      step(0, 0, 6'd0, 16'd0, 1, 0);
      idle(10);

      // R6: 20 hits into one bucket, read 42 crossings later
      cur_req = "R6 overflow";
      for (int i = 0; i < 20; i++) step(0, 1, 6'(xc), 16'(16'h1000 + i), 0, 0);
      strobes(42);
      step(0, 0, 6'd0, 16'd0, 1, 0);
      idle(30);

      // R10: six accepts on the same full bucket, only the sixth is rejected
      cur_req = "R10 burst";
      for (int i = 0; i < 5; i++) step(0, 0, 6'd0, 16'd0, 1, 0);
      @(posedge clk);
      #1;
      chk("R10 busy after four pending", 32'(busy), 1);
      step(0, 0, 6'd0, 16'd0, 1, 1);
      idle(110);
      chk("R10 busy cleared", 32'(busy), 0);

      // R8: hit aimed at the bucket being cleared
      cur_req = "R8 clear drop";
      step(1, 1, 6'(xc + 1), 16'hDEAD, 0, 0);
      idle(2);
      chk("R8 drop_count", 32'(drop_count), 32'(drops));

      // R8: hits gone after a full counter turn
      cur_req = "R8 reuse";
      for (int i = 0; i < 3; i++) step(0, 1, 6'(xc), 16'(16'h2000 + i), 0, 0);
      strobes(64 + 42);
      step(0, 0, 6'd0, 16'd0, 1, 0);
      idle(10);

      // R9: hit aimed at the bucket in the copy cycle
      cur_req = "R9 copy drop";
      for (int i = 0; i < 3; i++) step(0, 1, 6'(xc), 16'(16'h3000 + i), 0, 0);
      strobes(42);
      step(0, 0, 6'd0, 16'd0, 1, 0);
      step(0, 1, 6'(xc - 42), 16'hBEEF, 0, 2);
      idle(10);
      chk("R9 drop_count", 32'(drop_count), 32'(drops));

      // R2 R3 R5 R11: random traffic over several counter wraps
      cur_req = "R2 R3 R5 R11 random";
      for (int w = 0; w < 40; w++) begin
         for (int j = 0; j < 60; j++) begin
            bit s, hv;
            logic [5:0] ts;
            s  = ($urandom % 8) == 0;
            hv = ($urandom % 2) == 1;
            ts = 6'(xc) - 6'($urandom % 3);
            step(s, hv, ts, 16'($urandom), j == 30, 0);
         end
      end
      idle(30);
      chk("R11 all events delivered", 32'(exp_q.size()), 0);
      chk("R8 R9 final drop_count", 32'(drop_count), 32'(drops));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule